// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block samples a set of board configuration straps exactly once, at the moment an active-low power-good strobe is first seen low. The straps are three frequency-select bits, a function-select bit and a debug-select bit. The strobe is synchronized, and a low only counts as valid once it has held for two synchronized samples. That valid low sets a done flag and freezes the captured values. From then on the same pin serves as an active-high power-down request.

The frozen frequency bits are decoded into a two-bit CPU frequency code. The frozen function-select bit picks which clock family the downstream synthesizer drives. A test-mode input lifts the freeze so that the straps are sampled on every cycle. Analog thresholds, clock synthesis and output buffers belong elsewhere.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets as follows. `latched` goes to 0. `fs_q` goes to 3'b000. `fn_q` and `dbg_q` go to 0. `cpu_code` reads 2'd0 (100 MHz). `en_96m`=1, `en_27m`=0 and `sel_panel`=0. `pd_req` is 0.
- R2: The strobe pin passes through a two-stage synchronizer and is accepted as low once two consecutive synchronized samples are low. Say the pin falls before rising edge 1. Then `latched` rises, and the straps are captured, on rising edge 4.
- R3: A strobe low that lasts only one clock cycle never sets `latched`.
- R4: Once `latched` is 1 and `test_mode` is 0, changes on the straps leave `fs_q`, `fn_q` and `dbg_q` unchanged.
- R5: Once `latched` is 1, further strobe lows cause no new capture.
- R6: Once `latched` is 1, `pd_req` follows the pin, active high, through the two synchronizer stages. It changes two rising edges after the pin changes.
- R7: While `latched` is 0, `pd_req` stays 0 whatever the pin level.
- R8: While `test_mode` is 1, the straps are captured on every rising edge, even after `latched` is set.
- R9: Frequency decode from `fs_q` = {C,B,A} works as follows. When C=1 the code is 0 (100 MHz). When C=0, {B,A} = 00/01/10/11 gives code 0/1/2/3, meaning 100/133/166/200 MHz.
- R10: `fn_q`=0 selects the 96 MHz output (`en_96m`=1) and the 100 MHz serial reference (`sel_panel`=0). `fn_q`=1 selects the 27 MHz output (`en_27m`=1) and the flat-panel spread clock (`sel_panel`=1). `en_96m` and `en_27m` are never both 1.
- R11: `latched` stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_pin | input | 1 | Power-good strobe (active low) before latch, power-down request (active high) after |
| fs_in | input | 3 | Frequency-select straps {C,B,A} |
| fn_in | input | 1 | Function-select strap |
| dbg_in | input | 1 | Debug-select strap |
| test_mode | input | 1 | Lifts the one-shot freeze |
| fs_q | output | 3 | Captured frequency-select straps |
| fn_q | output | 1 | Captured function-select strap |
| dbg_q | output | 1 | Captured debug-select strap |
| cpu_code | output | 2 | CPU frequency code (0=100, 1=133, 2=166, 3=200 MHz) |
| en_96m | output | 1 | 96 MHz display output selected |
| en_27m | output | 1 | 27 MHz output selected |
| sel_panel | output | 1 | 1 = flat-panel spread clock, 0 = 100 MHz serial reference |
| latched | output | 1 | Capture done |
| pd_req | output | 1 | Power-down request |

## Verification
The done flag and the capture are due on the fourth rising edge after the pin falls: two synchronizer stages, one stability stage and the capture register. The bench therefore samples after the third edge, expecting no capture yet, and again after the fourth. `pd_req` is due two edges after a pin change and is checked after edge one and after edge two. In test mode a strap change shows up after a single edge. The decode outputs are combinational from the captured registers and are read in the same sampling slot. All inputs are driven and all outputs sampled on falling edges.

// File: rtl/strap_pkg.sv
// Package: shared widths, captured-strap record and CPU frequency codes.
// Assumes: reset defaults select 100 MHz CPU and the 96 MHz output.
package strap_pkg;
    localparam int FS_W = 3;

    typedef enum logic [1:0] {
        CPU_100 = 2'd0,
        CPU_133 = 2'd1,
        CPU_166 = 2'd2,
        CPU_200 = 2'd3
    } cpu_freq_e;

    typedef struct packed {
        logic [FS_W-1:0] fs;
        logic            fn;
        logic            dbg;
    } strap_t;

    localparam strap_t STRAP_DEFAULT = '{fs: '0, fn: 1'b0, dbg: 1'b0};
endpackage

// File: rtl/pg_sync.sv
// Module: pg_sync
// Synchronizes the strobe pin, then qualifies a low only after it has
// held for STABLE_SAMPLES consecutive synchronized samples.
// Assumes: pin idle level is high; reset forces every stage high.
module pg_sync #(
    parameter int SYNC_STAGES    = 2,
    parameter int STABLE_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic synced,
    output logic low_ok
);
    localparam int HIST_W = (STABLE_SAMPLES > 1) ? STABLE_SAMPLES - 1 : 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HIST_W-1:0]      hist_q;

    // Purpose: shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign synced = sync_q[SYNC_STAGES-1];

    generate
        if (STABLE_SAMPLES > 1) begin : g_hist
            // Purpose: remember previous synchronized samples for the filter.
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '1;
                else if (HIST_W == 1) hist_q <= synced;
                else hist_q <= {hist_q[HIST_W-2:0], synced};
            end
            assign low_ok = ~synced & ~(|hist_q);
        end else begin : g_nohist
            assign hist_q = '1;
            assign low_ok = ~synced;
        end
    endgenerate

    generate
        if (SYNC_STAGES == 2 && STABLE_SAMPLES == 2) begin : g_chk
            // R3: a qualified low means the raw pin was low on two earlier edges
            a_r3_low_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
                low_ok |-> (!$past(pin, 2) && !$past(pin, 3)));
        end
    endgenerate
endmodule

// File: rtl/strap_capture.sv
// Module: strap_capture
// Holds the one-shot strap capture, the done flag and the gated
// power-down request.
// Assumes: straps are stable around the qualifying strobe low.
module strap_capture
    import strap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   low_ok,
    input  logic   pin_hi,
    input  logic   test_mode,
    input  strap_t straps_in,
    output strap_t straps_q,
    output logic   latched,
    output logic   pd_req
);
    logic take_first;
    assign take_first = !latched && low_ok;

    // Purpose: capture straps on the first valid low, or every cycle in test mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            straps_q <= STRAP_DEFAULT;
            latched  <= 1'b0;
        end else if (take_first) begin
            straps_q <= straps_in;
            latched  <= 1'b1;
        end else if (test_mode) begin
            straps_q <= straps_in;
        end
    end

    // Purpose: the pin only requests power-down once capture is done.
    assign pd_req = latched & pin_hi;

    a_r11_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        latched |=> latched);
    a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !test_mode) |=> $stable(straps_q));
    a_r7_pd_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !latched |-> !pd_req);
    a_r2_rise_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> $past(low_ok));
    a_r8_test_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && test_mode) |=> (straps_q == $past(straps_in)));
endmodule

// File: rtl/clk_sel_decode.sv
// Module: clk_sel_decode
// Turns captured straps into a CPU frequency code and clock-family selects.
// Assumes: inputs come from registers; purely combinational.
module clk_sel_decode
    import strap_pkg::*;
(
    input  strap_t    straps,
    output cpu_freq_e cpu_code,
    output logic      en_96m,
    output logic      en_27m,
    output logic      sel_panel
);
    // Purpose: map {C,B,A} to the CPU frequency code, C=1 falls back to 100 MHz.
    always_comb begin
        if (straps.fs[FS_W-1]) cpu_code = CPU_100;
        else                   cpu_code = cpu_freq_e'(straps.fs[1:0]);
    end

    // Purpose: function select chooses exactly one of the 96/27 MHz paths.
    always_comb begin
        en_27m    = straps.fn;
        en_96m    = ~straps.fn;
        sel_panel = straps.fn;
    end
endmodule

// File: rtl/strap_latch_ctrl.sv
// Module: strap_latch_ctrl (top)
// Wires the strobe synchronizer, the one-shot capture and the decode.
// Assumes: single clock domain; straps meet setup around the strobe low.
module strap_latch_ctrl
    import strap_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int STABLE_SAMPLES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pg_pin,
    input  logic [FS_W-1:0] fs_in,
    input  logic            fn_in,
    input  logic            dbg_in,
    input  logic            test_mode,
    output logic [FS_W-1:0] fs_q,
    output logic            fn_q,
    output logic            dbg_q,
    output logic [1:0]      cpu_code,
    output logic            en_96m,
    output logic            en_27m,
    output logic            sel_panel,
    output logic            latched,
    output logic            pd_req
);
    logic      pin_hi;
    logic      low_ok;
    strap_t    straps_in;
    strap_t    straps_q;
    cpu_freq_e code;

    assign straps_in = '{fs: fs_in, fn: fn_in, dbg: dbg_in};

    pg_sync #(
        .SYNC_STAGES   (SYNC_STAGES),
        .STABLE_SAMPLES(STABLE_SAMPLES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pg_pin),
        .synced(pin_hi),
        .low_ok(low_ok)
    );

    strap_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .low_ok   (low_ok),
        .pin_hi   (pin_hi),
        .test_mode(test_mode),
        .straps_in(straps_in),
        .straps_q (straps_q),
        .latched  (latched),
        .pd_req   (pd_req)
    );

    clk_sel_decode u_dec (
        .straps   (straps_q),
        .cpu_code (code),
        .en_96m   (en_96m),
        .en_27m   (en_27m),
        .sel_panel(sel_panel)
    );

    assign fs_q     = straps_q.fs;
    assign fn_q     = straps_q.fn;
    assign dbg_q    = straps_q.dbg;
    assign cpu_code = code;

    // R10: the 96 MHz and 27 MHz paths are never both selected
    a_r10_one_family: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({en_96m, en_27m}) == 1);
endmodule

// File: tb/strap_latch_ctrl_tb.sv
module strap_latch_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pg_pin = 1'b1;
    logic [2:0] fs_in = 3'b000;
    logic       fn_in = 1'b0;
    logic       dbg_in = 1'b0;
    logic       test_mode = 1'b0;
    logic [2:0] fs_q;
    logic       fn_q, dbg_q, en_96m, en_27m, sel_panel, latched, pd_req;
    logic [1:0] cpu_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    strap_latch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pg_pin(pg_pin), .fs_in(fs_in), .fn_in(fn_in),
        .dbg_in(dbg_in), .test_mode(test_mode), .fs_q(fs_q), .fn_q(fn_q),
        .dbg_q(dbg_q), .cpu_code(cpu_code), .en_96m(en_96m), .en_27m(en_27m),
        .sel_panel(sel_panel), .latched(latched), .pd_req(pd_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pg_pin = 1'b1; test_mode = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drop the pin, hold it low and expect capture on the fourth edge.
    task automatic latch_with(input logic [2:0] fs, input logic fn, input logic dbg);
        fs_in = fs; fn_in = fn; dbg_in = dbg;
        pg_pin = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 no capture before edge 4", {31'd0, latched}, 32'd0);
        @(negedge clk);
        chk("R2 latched at edge 4", {31'd0, latched}, 32'd1);
        chk("R2 straps captured", {27'd0, fs_q, fn_q, dbg_q}, {27'd0, fs, fn, dbg});
    endtask

    task automatic t_reset();
        fs_in = 3'b111; fn_in = 1'b1; dbg_in = 1'b1;
        do_reset();
        chk("R1 latched", {31'd0, latched}, 32'd0);
        chk("R1 straps", {27'd0, fs_q, fn_q, dbg_q}, 32'd0);
        chk("R1 cpu_code", {30'd0, cpu_code}, 32'd0);
        chk("R1 selects", {29'd0, en_96m, en_27m, sel_panel}, 32'b100);
        chk("R1 pd_req", {31'd0, pd_req}, 32'd0);
    endtask

    task automatic t_glitch_and_pd_gate();
        do_reset();
        fs_in = 3'b011;
        @(negedge clk); pg_pin = 1'b0;
        @(negedge clk); pg_pin = 1'b1;
        repeat (6) @(negedge clk);
        chk("R3 one-cycle low ignored", {31'd0, latched}, 32'd0);
        chk("R3 straps untouched", {29'd0, fs_q}, 32'd0);
        chk("R7 pd_req held low before latch", {31'd0, pd_req}, 32'd0);
    endtask

    task automatic t_lock_and_pd();
        do_reset();
        latch_with(3'b010, 1'b1, 1'b1);
        fs_in = 3'b101; fn_in = 1'b0; dbg_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 straps frozen", {27'd0, fs_q, fn_q, dbg_q}, {27'd0, 3'b010, 1'b1, 1'b1});
        pg_pin = 1'b1;
        @(negedge clk);
        chk("R6 pd_req not yet", {31'd0, pd_req}, 32'd0);
        @(negedge clk);
        chk("R6 pd_req rises after 2 edges", {31'd0, pd_req}, 32'd1);
        pg_pin = 1'b0;
        @(negedge clk);
        chk("R6 pd_req still high", {31'd0, pd_req}, 32'd1);
        @(negedge clk);
        chk("R6 pd_req falls after 2 edges", {31'd0, pd_req}, 32'd0);
        repeat (4) @(negedge clk);
        chk("R5 new strobe low no recapture", {27'd0, fs_q, fn_q, dbg_q}, {27'd0, 3'b010, 1'b1, 1'b1});
        chk("R11 latched sticky", {31'd0, latched}, 32'd1);
    endtask

    task automatic t_test_mode();
        do_reset();
        latch_with(3'b001, 1'b0, 1'b0);
        test_mode = 1'b1;
        fs_in = 3'b110; fn_in = 1'b1; dbg_in = 1'b1;
        @(negedge clk);
        chk("R8 test mode recapture", {27'd0, fs_q, fn_q, dbg_q}, {27'd0, 3'b110, 1'b1, 1'b1});
        fs_in = 3'b011;
        @(negedge clk);
        chk("R8 test mode follows", {29'd0, fs_q}, {29'd0, 3'b011});
        test_mode = 1'b0;
        fs_in = 3'b000;
        repeat (2) @(negedge clk);
        chk("R4 freeze resumes", {29'd0, fs_q}, {29'd0, 3'b011});
    endtask

    task automatic t_decode();
        for (int i = 0; i < 8; i++) begin
            logic [1:0] exp_code;
            logic       f;
            exp_code = (i >= 4) ? 2'd0 : i[1:0];
            f = i[0];
            do_reset();
            latch_with(i[2:0], f, 1'b0);
            chk("R9 cpu_code", {30'd0, cpu_code}, {30'd0, exp_code});
            chk("R10 selects", {29'd0, en_96m, en_27m, sel_panel}, {29'd0, ~f, f, f});
        end
    endtask

    initial begin
        t_reset();
        t_glitch_and_pd_gate();
        t_lock_and_pd();
        t_test_mode();
        t_decode();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule